// File: doc/BRIEF.md
# Switched-Domain Power Sequencer

This controller owns the switchable power domain of a battery or adapter powered instrument. The main supply is always present and runs this block. A press of the power button (an active-low, asynchronous input) brings the switched domain up in a fixed order. First the supply-enable output goes high. Then, after a programmable settling interval, the downstream active-low reset is released. A later press takes the domain down in the opposite order, and so does a long stretch with no user activity. In both cases the downstream reset is asserted first, and the supply enable is dropped a programmable number of cycles after that.

An always-on, active-low power-up reset clears the controller when batteries or an adapter are first connected. It also causes a single-cycle request to clear the working memory. Activity is reported by a one-cycle strobe from the user-interface logic, and each strobe restarts the inactivity interval. The default timeout is set for roughly six minutes at a 1 MHz clock. A test can shorten it through a parameter.

Top module: `power_sequencer`

## Requirements
- R1: While porRstN is low, supplyEn, sysRstN and memClear are all 0, and the sequencer is in its off state.
- R2: When powerBtnN goes from high to low while the domain is off, supplyEn rises on the third rising clock edge that samples it low (two synchronizer stages and one edge-detect stage). sysRstN is still 0 at that moment.
- R3: sysRstN rises exactly SETTLE_CYCLES clock edges after supplyEn rises.
- R4: Only a high-to-low transition of the synchronized button counts as a press. A button that stays low, and the release of the button, cause no further transition.
- R5: A press while running drops sysRstN on the third edge that samples the button low, with supplyEn still 1. supplyEn falls exactly DOWN_CYCLES edges later.
- R6: When the domain is running and IDLE_CYCLES consecutive clock edges pass with no activity strobe, sysRstN falls on the last of those edges. The rest of the power-down follows as in R5.
- R7: An activity strobe that is high at a rising edge while running restarts the inactivity interval. sysRstN then falls IDLE_CYCLES edges after that edge.
- R8: memClear is high for exactly one cycle, on the first rising edge after porRstN is released, and never again until the next power-up reset.
- R9: Presses that arrive while the supply is settling or while it is shutting down are ignored, and the ordering and cycle counts of R3 and R5 still hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| porRstN | input | 1 | Always-on power-up reset, active low, asynchronous |
| powerBtnN | input | 1 | Power button, active low, asynchronous |
| activity | input | 1 | One-cycle user activity strobe, synchronous to clk |
| supplyEn | output | 1 | Enable for the switched supplies (1 = on) |
| sysRstN | output | 1 | Reset for the switched domain, active low |
| memClear | output | 1 | One-cycle working-memory clear request after power-up reset |

## Verification
The assertions take the activity strobe to be synchronous to clk. They take a button press to stay low long enough to pass both synchronizer stages, and a release to return high before the next press is expected to count. The stimulus changes every input one time unit after a rising edge. It holds each button level for at least three edges, except where it deliberately packs a release and a new press inside a settling or shutdown interval. Activity pulses are exactly one cycle wide, and they are swept over every position inside the inactivity window.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    PS_OFF      = 2'd0,
    PS_ENABLING = 2'd1,
    PS_RUNNING  = 2'd2,
    PS_SHUTTING = 2'd3
  } pwrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic seqRun;   // sequencing counter advances
    logic seqDown;  // select the power-down interval
    logic idleRun;  // inactivity counter advances
  } seqCtl_t;

  // events from datapath to control
  typedef struct packed {
    logic press;        // one-cycle button press
    logic seqDone;      // sequencing interval complete
    logic idleExpired;  // inactivity window elapsed
  } seqStat_t;

endpackage

// File: rtl/pwrseq_dp.sv
module pwrseq_dp
  import pwrseq_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 1000,
  parameter int unsigned DOWN_CYCLES   = 100,
  parameter int unsigned IDLE_CYCLES   = 360000000
) (
  input  logic     clk,
  input  logic     porRstN,
  input  logic     powerBtnN,
  input  logic     activity,
  input  seqCtl_t  ctl,
  output seqStat_t stat,
  output logic     memClear
);

  localparam int unsigned SEQ_MAX = (SETTLE_CYCLES > DOWN_CYCLES) ? SETTLE_CYCLES : DOWN_CYCLES;
  localparam int SEQ_W  = $clog2(SEQ_MAX) + 1;
  localparam int IDLE_W = $clog2(IDLE_CYCLES) + 1;
  localparam logic [SEQ_W-1:0]  SETTLE_LAST = SEQ_W'(SETTLE_CYCLES - 1);
  localparam logic [SEQ_W-1:0]  DOWN_LAST   = SEQ_W'(DOWN_CYCLES - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST   = IDLE_W'(IDLE_CYCLES - 1);

  // button synchronizer and falling-edge detector
  logic [1:0] btnSync;
  logic       btnPrev;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      btnSync <= 2'b11;
      btnPrev <= 1'b1;
    end else begin
      btnSync <= {btnSync[0], powerBtnN};
      btnPrev <= btnSync[1];
    end
  end

  assign stat.press = btnPrev & ~btnSync[1];

  // shared sequencing counter
  logic [SEQ_W-1:0] seqCnt;
  logic [SEQ_W-1:0] seqLast;

  assign seqLast      = ctl.seqDown ? DOWN_LAST : SETTLE_LAST;
  assign stat.seqDone = ctl.seqRun && (seqCnt == seqLast);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      seqCnt <= '0;
    end else if (!ctl.seqRun || stat.seqDone) begin
      seqCnt <= '0;
    end else begin
      seqCnt <= seqCnt + 1'b1;
    end
  end

  // inactivity counter
  logic [IDLE_W-1:0] idleCnt;

  assign stat.idleExpired = ctl.idleRun && !activity && (idleCnt == IDLE_LAST);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      idleCnt <= '0;
    end else if (!ctl.idleRun || activity || stat.idleExpired) begin
      idleCnt <= '0;
    end else begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // one-shot memory clear after power-up reset
  logic clrDone;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      clrDone  <= 1'b0;
      memClear <= 1'b0;
    end else begin
      clrDone  <= 1'b1;
      memClear <= !clrDone;
    end
  end

  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!porRstN)
    memClear |=> !memClear); // R8

  AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!porRstN)
    stat.press |=> !stat.press); // R4

  AST_IDLE_IN_RANGE: assert property (@(posedge clk) disable iff (!porRstN)
    idleCnt <= IDLE_LAST); // R6

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic     clk,
  input  logic     porRstN,
  input  seqStat_t stat,
  output seqCtl_t  ctl,
  output logic     supplyEn,
  output logic     sysRstN
);

  pwrState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      PS_OFF:      if (stat.press)                     stateNext = PS_ENABLING;
      PS_ENABLING: if (stat.seqDone)                   stateNext = PS_RUNNING;
      PS_RUNNING:  if (stat.press || stat.idleExpired) stateNext = PS_SHUTTING;
      PS_SHUTTING: if (stat.seqDone)                   stateNext = PS_OFF;
      default:                                         stateNext = PS_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) state <= PS_OFF;
    else          state <= stateNext;
  end

  assign ctl.seqRun  = (state == PS_ENABLING) || (state == PS_SHUTTING);
  assign ctl.seqDown = (state == PS_SHUTTING);
  assign ctl.idleRun = (state == PS_RUNNING);

  assign supplyEn = (state != PS_OFF);
  assign sysRstN  = (state == PS_RUNNING);

  AST_ENABLE_ON_PRESS: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(supplyEn) |-> ($past(stat.press) && !sysRstN)); // R2

  AST_RELEASE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(sysRstN) |-> ($past(stat.seqDone) && supplyEn)); // R3

  AST_RESET_FIRST_ON_DOWN: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(sysRstN) |-> (supplyEn && ($past(stat.press) || $past(stat.idleExpired)))); // R5

  AST_DISABLE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(supplyEn) |-> ($past(stat.seqDone) && !$past(sysRstN))); // R9

  AST_NO_RESET_WHILE_OFF: assert property (@(posedge clk) disable iff (!porRstN)
    !supplyEn |-> !sysRstN); // R1

endmodule

// File: rtl/power_sequencer.sv
module power_sequencer
  import pwrseq_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 1000,
  parameter int unsigned DOWN_CYCLES   = 100,
  parameter int unsigned IDLE_CYCLES   = 360000000
) (
  input  logic clk,
  input  logic porRstN,
  input  logic powerBtnN,
  input  logic activity,
  output logic supplyEn,
  output logic sysRstN,
  output logic memClear
);

  seqCtl_t  ctl;
  seqStat_t stat;

  pwrseq_dp #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .DOWN_CYCLES  (DOWN_CYCLES),
    .IDLE_CYCLES  (IDLE_CYCLES)
  ) u_dp (
    .clk      (clk),
    .porRstN  (porRstN),
    .powerBtnN(powerBtnN),
    .activity (activity),
    .ctl      (ctl),
    .stat     (stat),
    .memClear (memClear)
  );

  pwrseq_ctrl u_ctrl (
    .clk     (clk),
    .porRstN (porRstN),
    .stat    (stat),
    .ctl     (ctl),
    .supplyEn(supplyEn),
    .sysRstN (sysRstN)
  );

endmodule

// File: tb/power_sequencer_tb.sv
module power_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int S_CYC = 8;
  localparam int D_CYC = 6;
  localparam int I_CYC = 20;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic porRstN, powerBtnN, activity;
  logic supplyEn, sysRstN, memClear;

  int checks = 0;
  int fails = 0;
  int clrSeen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  power_sequencer #(
    .SETTLE_CYCLES(S_CYC),
    .DOWN_CYCLES  (D_CYC),
    .IDLE_CYCLES  (I_CYC)
  ) u_dut (
    .clk      (clk),
    .porRstN  (porRstN),
    .powerBtnN(powerBtnN),
    .activity (activity),
    .supplyEn (supplyEn),
    .sysRstN  (sysRstN),
    .memClear (memClear)
  );

  always @(negedge clk) if (porRstN === 1'b1 && memClear === 1'b1) clrSeen++;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect1(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // press from off, check R2/R3 timing, return at the edge that releases reset
  task automatic powerOn();
    powerBtnN = 1'b0;
    tick(2);
    expect1("R2", "supplyEn before third edge", supplyEn, 1'b0);
    tick(1);
    expect1("R2", "supplyEn on third edge", supplyEn, 1'b1);
    expect1("R2", "sysRstN held at enable", sysRstN, 1'b0);
    tick(S_CYC - 1);
    expect1("R3", "sysRstN before settle end", sysRstN, 1'b0);
    tick(1);
    expect1("R3", "sysRstN at settle end", sysRstN, 1'b1);
  endtask

  // from sysRstN fall, check the power-down hold
  task automatic checkDown(input string req);
    expect1(req, "supplyEn kept after reset", supplyEn, 1'b1);
    tick(D_CYC - 1);
    expect1(req, "supplyEn before hold end", supplyEn, 1'b1);
    tick(1);
    expect1(req, "supplyEn after hold", supplyEn, 1'b0);
  endtask

  initial begin
    porRstN = 1'b0;
    powerBtnN = 1'b1;
    activity = 1'b0;
    tick(3);
    expect1("R1", "supplyEn in reset", supplyEn, 1'b0);
    expect1("R1", "sysRstN in reset", sysRstN, 1'b0);
    expect1("R1", "memClear in reset", memClear, 1'b0);
    powerBtnN = 1'b0;
    tick(4);
    expect1("R1", "button ignored in reset", supplyEn, 1'b0);
    powerBtnN = 1'b1;
    porRstN = 1'b1;
    tick(1);
    expect1("R8", "memClear first edge", memClear, 1'b1);
    tick(1);
    expect1("R8", "memClear second edge", memClear, 1'b0);
    expect1("R1", "still off after reset", supplyEn, 1'b0);
    tick(3);

    // pure inactivity timeout
    powerOn();
    powerBtnN = 1'b1;
    tick(I_CYC - 1);
    expect1("R6", "sysRstN before timeout", sysRstN, 1'b1);
    tick(1);
    expect1("R6", "sysRstN at timeout", sysRstN, 1'b0);
    checkDown("R6");
    tick(3);

    // sweep activity strobe over every position in the window
    for (int j = 1; j < I_CYC; j++) begin
      powerOn();
      powerBtnN = 1'b1;
      tick(j - 1);
      activity = 1'b1;
      tick(1);
      activity = 1'b0;
      tick(I_CYC - 1);
      expect1("R7", $sformatf("restart offset %0d still running", j), sysRstN, 1'b1);
      tick(1);
      expect1("R7", $sformatf("restart offset %0d timeout", j), sysRstN, 1'b0);
      tick(D_CYC);
      expect1("R6", $sformatf("offset %0d supply off", j), supplyEn, 1'b0);
      tick(3);
    end

    // held button: one transition only, release has no effect
    powerOn();
    tick(10);
    expect1("R4", "held button keeps running", sysRstN, 1'b1);
    expect1("R4", "held button keeps supply", supplyEn, 1'b1);
    powerBtnN = 1'b1;
    tick(4);
    expect1("R4", "release keeps running", sysRstN, 1'b1);

    // button power-down
    powerBtnN = 1'b0;
    tick(2);
    expect1("R5", "sysRstN before third edge", sysRstN, 1'b1);
    tick(1);
    expect1("R5", "sysRstN on third edge", sysRstN, 1'b0);
    checkDown("R5");
    tick(6);
    expect1("R4", "held after off stays off", supplyEn, 1'b0);
    powerBtnN = 1'b1;
    tick(4);
    expect1("R4", "release while off stays off", supplyEn, 1'b0);

    // press during settling is ignored
    powerBtnN = 1'b0;
    tick(3);
    expect1("R9", "enabling entered", supplyEn, 1'b1);
    powerBtnN = 1'b1;
    tick(1);
    powerBtnN = 1'b0;
    tick(S_CYC - 2);
    expect1("R9", "settle not cut short", sysRstN, 1'b0);
    expect1("R9", "supply kept in settle", supplyEn, 1'b1);
    tick(1);
    expect1("R9", "release on schedule", sysRstN, 1'b1);
    tick(4);
    expect1("R9", "still running after ignored press", sysRstN, 1'b1);
    powerBtnN = 1'b1;
    tick(I_CYC + D_CYC);
    expect1("R6", "timed out after ignored press", supplyEn, 1'b0);
    tick(3);

    // press during shutdown is ignored
    powerOn();
    powerBtnN = 1'b1;
    tick(3);
    powerBtnN = 1'b0;
    tick(3);
    expect1("R5", "shutdown entered", sysRstN, 1'b0);
    powerBtnN = 1'b1;
    tick(1);
    powerBtnN = 1'b0;
    tick(D_CYC - 2);
    expect1("R9", "supply held in shutdown", supplyEn, 1'b1);
    tick(1);
    expect1("R9", "supply off on schedule", supplyEn, 1'b0);
    tick(6);
    expect1("R9", "no restart after ignored press", supplyEn, 1'b0);
    expect1("R9", "reset held after ignored press", sysRstN, 1'b0);
    powerBtnN = 1'b1;
    tick(3);

    checks++;
    if (clrSeen != 1) begin
      fails++;
      $display("FAIL R8 memClear cycles: actual %0d expected 1", clrSeen);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule